// File: doc/BRIEF.md
# Configurable-Sense Interrupt Aggregator

This block collects 64 interrupt request lines into three separate interrupt outputs. The lines are handled as two banks of 32 bits: lines 0 to 31 form the low bank and lines 32 to 63 form the high bank. Every input passes through a two-stage synchroniser. A single trigger-sense stage then turns each line into a normalised trigger bit. Software picks the sense for each line from two configuration bit-planes, called rise and fall: rise only selects rising edge, fall only selects falling edge, neither selects active-high level, and both select active-low level. In edge modes a detected transition sets a sticky latch. The latch stays set until software acknowledges the line.

Three output controllers share these trigger bits. Each controller keeps its own enable mask and its own software-force bits. A controller's raw view is the trigger bits ORed with its force bits. Its masked view is the raw view ANDed with its enables, and its output is high whenever any masked bit is set. All state is reached through a plain 32-bit register port with word addresses. Reads are combinational from `bus_addr`. Writes take effect on the rising clock edge while `bus_wr` is high. Every state-changing register uses write-1-to-set or write-1-to-clear, so a zero bit in a write leaves state unchanged. The bus carries no stream, so it has no valid/ready handshake and no back-pressure: one access per cycle is always accepted.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all enables, force bits, edge latches and sense configuration are zero. Every line is active-high level and disabled, `irq_out` is 0, and every register reads 0 while all inputs are low.
- R2: A line whose rise and fall bits are both 0 shows its synchronised input level in bit n of every controller's raw word (controller word offset 1). The bit follows the input two clock edges after the input changes.
- R3: A line whose rise and fall bits are both 1 shows the inverted synchronised input level.
- R4: A line with rise=1 and fall=0 sets its latch on a 0-to-1 input transition. The latch stays set after the input returns low, until it is acknowledged.
- R5: A line with rise=0 and fall=1 sets its latch only on a 1-to-0 transition. A 0-to-1 transition leaves it clear.
- R6: Writing 1 to bit n of the sense acknowledge word (sense word offset 1, which reads as the latches) clears latch n. Writing 0 has no effect.
- R7: A controller's enable-set word (offset 2) sets enables on 1 bits, and its enable-clear word (offset 3) clears them on 1 bits. Both words read the enable mask. The masked word (offset 0) reads raw AND enable.
- R8: A controller's force-set word (offset 4) and force-clear word (offset 5) set and clear its force bits on 1 bits. Force bits OR into that controller's raw word only.
- R9: `irq_out[k]` is high exactly when controller k has at least one masked bit set. Controllers do not affect one another's enables or force bits.
- R10: Controllers sit at word addresses 0x00, 0x40 and 0xC0, with their high bank 6 words above. The sense block sits at word 0x80, with its high bank at word 0x88. High-bank bit b maps to line 32+b.
- R11: Sense word offsets: 2 reads the rise plane, 3 reads the fall plane, 4 and 5 set and clear rise, 6 and 7 set and clear fall. Offsets 4 and 5 read back rise, and 6 and 7 read back fall. Writes to offsets 2 and 3 are ignored. Unmapped word addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Interrupt request lines, asynchronous to clk |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 3 | One aggregated interrupt per controller |

## Verification
The assertions assume that only one register is written per cycle, so a set alias and its clear alias never act in the same cycle. The latch assertions also assume that any edge arriving in the same cycle as an acknowledge takes priority. The stimulus drives inputs and bus fields on the falling edge. It holds each input level for at least four cycles, so the synchroniser and the edge detector see every transition. It never acknowledges a line in the same cycle that line's edge is detected.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int BANK_W      = 32;
  localparam int ADDR_W      = 8;
  localparam int NUM_CTRL    = 3;
  localparam int CTRL_STRIDE = 6;   // words per controller bank
  localparam int SENSE_STRIDE = 8;  // words per sense bank

  localparam logic [ADDR_W-1:0] CTRL_BASE [NUM_CTRL] = '{8'h00, 8'h40, 8'hC0};
  localparam logic [ADDR_W-1:0] SENSE_BASE = 8'h80;

  // controller word offsets
  localparam int C_MASKED = 0, C_RAW = 1, C_EN_SET = 2, C_EN_CLR = 3,
                 C_F_SET = 4, C_F_CLR = 5;
  // sense word offsets
  localparam int S_TRIG = 0, S_ACK = 1, S_RISE = 2, S_FALL = 3,
                 S_R_SET = 4, S_R_CLR = 5, S_F_SET = 6, S_F_CLR = 7;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_sense.sv
module irq_sense #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] rise_set,
  input  logic [N-1:0] rise_clr,
  input  logic [N-1:0] fall_set,
  input  logic [N-1:0] fall_clr,
  input  logic [N-1:0] ack,
  output logic [N-1:0] trig,
  output logic [N-1:0] latch_q,
  output logic [N-1:0] rise_cfg,
  output logic [N-1:0] fall_cfg
);
  logic [N-1:0] prev_q, up_ev, down_ev, set_ev, edge_mode, level_val;

  always_comb begin
    up_ev     = lines & ~prev_q;
    down_ev   = ~lines & prev_q;
    edge_mode = rise_cfg ^ fall_cfg;
    set_ev    = (rise_cfg & ~fall_cfg & up_ev) | (~rise_cfg & fall_cfg & down_ev);
    level_val = lines ^ rise_cfg;   // both planes set -> inverted
    trig      = (edge_mode & latch_q) | (~edge_mode & level_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      latch_q  <= '0;
      rise_cfg <= '0;
      fall_cfg <= '0;
    end else begin
      prev_q   <= lines;
      latch_q  <= (latch_q & ~ack) | set_ev;
      rise_cfg <= (rise_cfg | rise_set) & ~rise_clr;
      fall_cfg <= (fall_cfg | fall_set) & ~fall_clr;
    end
  end

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != '0) |=> ((latch_q & $past(ack & ~set_ev)) == '0));

  // R4
  latch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack == '0) |=> ((latch_q & $past(latch_q)) == $past(latch_q)));
endmodule

// File: rtl/irq_out_ctrl.sv
module irq_out_ctrl #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] en_set,
  input  logic [N-1:0] en_clr,
  input  logic [N-1:0] frc_set,
  input  logic [N-1:0] frc_clr,
  output logic [N-1:0] en_q,
  output logic [N-1:0] frc_q,
  output logic [N-1:0] raw,
  output logic [N-1:0] masked,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      frc_q <= '0;
    end else begin
      en_q  <= (en_q | en_set) & ~en_clr;
      frc_q <= (frc_q | frc_set) & ~frc_clr;
    end
  end

  always_comb begin
    raw    = trig | frc_q;
    masked = raw & en_q;
    irq    = |masked;
  end

  // R7
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr != '0) |=> ((en_q & $past(en_clr)) == '0));

  // R8
  force_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_clr != '0) |=> ((frc_q & $past(frc_clr)) == '0));

  // R9
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_q != '0));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int N_LINES     = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_LINES-1:0]  irq_in,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BANK_W-1:0]   bus_wdata,
  output logic [BANK_W-1:0]   bus_rdata,
  output logic [NUM_CTRL-1:0] irq_out
);
  localparam int BANKS = N_LINES / BANK_W;

  function automatic logic [N_LINES-1:0] place(input logic [BANK_W-1:0] d, input int b);
    logic [N_LINES-1:0] v;
    v = '0;
    v[b*BANK_W +: BANK_W] = d;
    return v;
  endfunction

  function automatic logic [BANK_W-1:0] pick(input logic [N_LINES-1:0] v, input int b);
    return v[b*BANK_W +: BANK_W];
  endfunction

  logic [N_LINES-1:0] lines_s;
  logic [N_LINES-1:0] trig, latch_q, rise_cfg, fall_cfg;
  logic [N_LINES-1:0] s_rset, s_rclr, s_fset, s_fclr, s_ack;

  irq_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_in), .q(lines_s)
  );

  // sense block decode
  logic [ADDR_W-1:0] s_off;
  logic              s_hit;
  int                s_bank, s_idx;
  logic [N_LINES-1:0] s_wmask;

  always_comb begin
    s_off   = bus_addr - SENSE_BASE;
    s_hit   = (bus_addr >= SENSE_BASE) && (int'(s_off) < SENSE_STRIDE*BANKS);
    s_bank  = int'(s_off) / SENSE_STRIDE;
    s_idx   = int'(s_off) % SENSE_STRIDE;
    s_wmask = (s_hit && bus_wr) ? place(bus_wdata, s_bank) : '0;
    s_ack   = (s_idx == S_ACK)   ? s_wmask : '0;
    s_rset  = (s_idx == S_R_SET) ? s_wmask : '0;
    s_rclr  = (s_idx == S_R_CLR) ? s_wmask : '0;
    s_fset  = (s_idx == S_F_SET) ? s_wmask : '0;
    s_fclr  = (s_idx == S_F_CLR) ? s_wmask : '0;
  end

  irq_sense #(.N(N_LINES)) u_sense (
    .clk(clk), .rst_n(rst_n), .lines(lines_s),
    .rise_set(s_rset), .rise_clr(s_rclr), .fall_set(s_fset), .fall_clr(s_fclr),
    .ack(s_ack), .trig(trig), .latch_q(latch_q),
    .rise_cfg(rise_cfg), .fall_cfg(fall_cfg)
  );

  logic [BANK_W-1:0] c_rd  [NUM_CTRL];
  logic              c_hit [NUM_CTRL];

  for (genvar k = 0; k < NUM_CTRL; k++) begin : g_ctrl
    logic [ADDR_W-1:0]  off;
    int                 bank, idx;
    logic [N_LINES-1:0] wmask, en_set, en_clr, frc_set, frc_clr;
    logic [N_LINES-1:0] en_q, frc_q, raw, masked;

    always_comb begin
      off        = bus_addr - CTRL_BASE[k];
      c_hit[k]   = (bus_addr >= CTRL_BASE[k]) && (int'(off) < CTRL_STRIDE*BANKS);
      bank       = int'(off) / CTRL_STRIDE;
      idx        = int'(off) % CTRL_STRIDE;
      wmask      = (c_hit[k] && bus_wr) ? place(bus_wdata, bank) : '0;
      en_set     = (idx == C_EN_SET) ? wmask : '0;
      en_clr     = (idx == C_EN_CLR) ? wmask : '0;
      frc_set    = (idx == C_F_SET)  ? wmask : '0;
      frc_clr    = (idx == C_F_CLR)  ? wmask : '0;
    end

    irq_out_ctrl #(.N(N_LINES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .trig(trig),
      .en_set(en_set), .en_clr(en_clr), .frc_set(frc_set), .frc_clr(frc_clr),
      .en_q(en_q), .frc_q(frc_q), .raw(raw), .masked(masked), .irq(irq_out[k])
    );

    always_comb begin
      c_rd[k] = '0;
      if (c_hit[k]) begin
        case (idx)
          C_MASKED:           c_rd[k] = pick(masked, bank);
          C_RAW:              c_rd[k] = pick(raw, bank);
          C_EN_SET, C_EN_CLR: c_rd[k] = pick(en_q, bank);
          C_F_SET, C_F_CLR:   c_rd[k] = pick(frc_q, bank);
          default:            c_rd[k] = '0;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (s_hit) begin
      case (s_idx)
        S_TRIG:                  bus_rdata = pick(trig, s_bank);
        S_ACK:                   bus_rdata = pick(latch_q, s_bank);
        S_RISE, S_R_SET, S_R_CLR: bus_rdata = pick(rise_cfg, s_bank);
        S_FALL, S_F_SET, S_F_CLR: bus_rdata = pick(fall_cfg, s_bank);
        default:                 bus_rdata = '0;
      endcase
    end
    for (int k = 0; k < NUM_CTRL; k++)
      if (c_hit[k]) bus_rdata = c_rd[k];
  end

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_hit && !c_hit[0] && !c_hit[1] && !c_hit[2]) |-> (bus_rdata == '0));
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_out;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;  // 250 MHz

  irq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  // op: 0 write, 1 read-compare, 2 drive low-bank inputs and settle, 3 compare irq_out
  // fields: {op[1:0], addr[7:0], data[31:0], expect[31:0], req[3:0]}
  localparam int NV = 62;
  localparam logic [77:0] VEC [NV] = '{
    {2'd1, 8'h82, 32'h0, 32'h0, 4'd1},          // R1 rise plane clear
    {2'd3, 8'h00, 32'h0, 32'h0, 4'd1},          // R1 outputs low
    {2'd0, 8'h02, 32'hF, 32'h0, 4'd7},          // R7 enable lines 0-3 on ctrl0
    {2'd1, 8'h02, 32'h0, 32'hF, 4'd7},          // R7
    {2'd2, 8'h00, 32'h1, 32'h0, 4'd2},          // R2 line0 high
    {2'd1, 8'h01, 32'h0, 32'h1, 4'd2},          // R2
    {2'd1, 8'h00, 32'h0, 32'h1, 4'd7},          // R7 masked
    {2'd3, 8'h00, 32'h0, 32'h1, 4'd9},          // R9
    {2'd1, 8'h41, 32'h0, 32'h1, 4'd9},          // R9 ctrl1 raw
    {2'd1, 8'h40, 32'h0, 32'h0, 4'd9},          // R9 ctrl1 not enabled
    {2'd2, 8'h00, 32'h0, 32'h0, 4'd2},          // R2
    {2'd1, 8'h01, 32'h0, 32'h0, 4'd2},          // R2
    {2'd0, 8'h84, 32'h2, 32'h0, 4'd3},          // R3 line1 rise
    {2'd0, 8'h86, 32'h2, 32'h0, 4'd3},          // R3 line1 fall -> level-low
    {2'd1, 8'h82, 32'h0, 32'h2, 4'd11},         // R11
    {2'd1, 8'h83, 32'h0, 32'h2, 4'd11},         // R11
    {2'd1, 8'h01, 32'h0, 32'h2, 4'd3},          // R3 low input asserts
    {2'd2, 8'h00, 32'h2, 32'h0, 4'd3},          // R3
    {2'd1, 8'h01, 32'h0, 32'h0, 4'd3},          // R3
    {2'd0, 8'h84, 32'h4, 32'h0, 4'd4},          // R4 line2 rising
    {2'd2, 8'h00, 32'h6, 32'h0, 4'd4},          // R4
    {2'd1, 8'h01, 32'h0, 32'h4, 4'd4},          // R4
    {2'd2, 8'h00, 32'h2, 32'h0, 4'd4},          // R4 input drops
    {2'd1, 8'h01, 32'h0, 32'h4, 4'd4},          // R4 sticky
    {2'd1, 8'h81, 32'h0, 32'h4, 4'd6},          // R6 latch view
    {2'd0, 8'h81, 32'h0, 32'h0, 4'd6},          // R6 zero write
    {2'd1, 8'h01, 32'h0, 32'h4, 4'd6},          // R6
    {2'd0, 8'h81, 32'h4, 32'h0, 4'd6},          // R6 ack
    {2'd1, 8'h01, 32'h0, 32'h0, 4'd6},          // R6
    {2'd0, 8'h86, 32'h8, 32'h0, 4'd5},          // R5 line3 falling
    {2'd2, 8'h00, 32'hA, 32'h0, 4'd5},          // R5 rise ignored
    {2'd1, 8'h01, 32'h0, 32'h0, 4'd5},          // R5
    {2'd2, 8'h00, 32'h2, 32'h0, 4'd5},          // R5 fall
    {2'd1, 8'h01, 32'h0, 32'h8, 4'd5},          // R5
    {2'd0, 8'h81, 32'h8, 32'h0, 4'd6},          // R6
    {2'd1, 8'h01, 32'h0, 32'h0, 4'd6},          // R6
    {2'd0, 8'hC4, 32'h10, 32'h0, 4'd8},         // R8 force ctrl2 line4
    {2'd1, 8'hC1, 32'h0, 32'h10, 4'd8},         // R8
    {2'd1, 8'hC0, 32'h0, 32'h0, 4'd8},          // R8
    {2'd3, 8'h00, 32'h0, 32'h0, 4'd9},          // R9
    {2'd0, 8'hC2, 32'h10, 32'h0, 4'd9},         // R9
    {2'd3, 8'h00, 32'h0, 32'h4, 4'd9},          // R9 only ctrl2
    {2'd1, 8'h01, 32'h0, 32'h0, 4'd8},          // R8 ctrl0 unaffected
    {2'd0, 8'hC5, 32'h10, 32'h0, 4'd8},         // R8
    {2'd3, 8'h00, 32'h0, 32'h0, 4'd8},          // R8
    {2'd0, 8'h03, 32'h0, 32'h0, 4'd7},          // R7 zero clear
    {2'd1, 8'h02, 32'h0, 32'hF, 4'd7},          // R7
    {2'd0, 8'h03, 32'h1, 32'h0, 4'd7},          // R7
    {2'd1, 8'h02, 32'h0, 32'hE, 4'd7},          // R7
    {2'd1, 8'h20, 32'h0, 32'h0, 4'd11},         // R11 unmapped
    {2'd1, 8'h85, 32'h0, 32'h6, 4'd11},         // R11 alias
    {2'd1, 8'h87, 32'h0, 32'hA, 4'd11},         // R11 alias
    {2'd0, 8'h0A, 32'h80000000, 32'h0, 4'd10},  // R10 high force line63
    {2'd1, 8'h07, 32'h0, 32'h80000000, 4'd10},  // R10
    {2'd0, 8'h08, 32'h80000000, 32'h0, 4'd10},  // R10
    {2'd1, 8'h06, 32'h0, 32'h80000000, 4'd10},  // R10
    {2'd3, 8'h00, 32'h0, 32'h1, 4'd10},         // R10
    {2'd0, 8'h0B, 32'h80000000, 32'h0, 4'd10},  // R10
    {2'd3, 8'h00, 32'h0, 32'h0, 4'd10},         // R10
    {2'd0, 8'h8C, 32'h1, 32'h0, 4'd10},         // R10 line32 rising
    {2'd1, 8'h8A, 32'h0, 32'h1, 4'd10},         // R10
    {2'd1, 8'h82, 32'h0, 32'h6, 4'd10}          // R10 low plane intact
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [77:0] v;
      v = VEC[i];
      case (v[77:76])
        2'd0: wr(v[75:68], v[67:36]);
        2'd1: rd(int'(v[3:0]), v[75:68], v[35:4]);
        2'd2: begin @(negedge clk); irq_in[31:0] = v[67:36]; settle(); end
        default: begin @(negedge clk); #1; check(int'(v[3:0]), {29'd0, irq_out}, v[35:4]); end
      endcase
    end

    // R10: high-bank rising edge on line 32
    @(negedge clk); irq_in[32] = 1'b1; settle();
    rd(10, 8'h07, 32'h1);
    rd(10, 8'h89, 32'h1);

    // R1: reset mid-run clears everything
    @(negedge clk); irq_in = '0; settle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(1, 8'h82, 32'h0);
    rd(1, 8'h83, 32'h0);
    rd(1, 8'h02, 32'h0);
    rd(1, 8'h81, 32'h0);
    rd(1, 8'hC1, 32'h0);
    @(negedge clk); #1;
    check(1, {29'd0, irq_out}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule